// File: doc/BRIEF.md
# Data-Processing Operand Decoder

This block turns one 32-bit data-processing instruction word into a decoded operand record. It extracts the destination and source register numbers and classifies the flexible second operand as a rotated immediate, a register shifted by a constant, or a register shifted by a register amount. For the immediate form it produces the expanded 32-bit constant. For the shifted-register forms it produces a canonical shift kind and amount.

Two normalisations make the record easier for later stages to consume. First, constant shifts of zero are folded into canonical forms: a left shift by zero becomes "no shift", and a rotate by zero becomes a one-bit rotate through carry. Second, the register operand list is reshaped for opcodes that do not use all three slots. Compare-type opcodes write no result, so their first source moves into the first slot. Move-type opcodes have no first source, so their flexible operand moves up into the second slot.

The block also reports whether flags are written, whether the operation writes the program counter (an indirect branch), and whether the shift needs an extra internal cycle. It does not execute the operation, read registers or evaluate the condition field. The record is registered: it appears one clock after an input is presented with its valid.

Top module: `dp_operand_decode`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one rising clock edge. While `in_valid` is low, the record fields hold their last values. An asserted active-low `rst_n` clears `out_valid` and every record field to zero.
- R2: When word bit 25 is 1 (immediate form), `out_kind` is 0 and `out_imm` is bits [7:0] rotated right by twice the value of bits [11:8]. In this form `out_shift_type`, `out_shift_amt`, `out_rm`, `out_rs` and `out_extra_cycle` are all 0.
- R3: When bit 25 is 0 and bit 4 is 0, `out_kind` is 1 and the register to shift comes from bits [3:0] on `out_rm`. The amount comes from bits [11:7] on `out_shift_amt`. The type comes from bits [6:5] on `out_shift_type`, with codes 00 giving left shift (code 1), 01 giving logical right shift (2), 10 giving arithmetic right shift (3) and 11 giving rotate right (4). In this form `out_imm`, `out_rs` and `out_extra_cycle` are 0.
- R4: A constant left shift by zero is reported as `out_shift_type` = 0 (no shift).
- R5: A constant rotate by zero is reported as `out_shift_type` = 5 (rotate through carry) with amount 0. Logical and arithmetic right shifts by zero keep their type code and amount 0.
- R6: When bit 25 is 0 and bit 4 is 1, `out_kind` is 2, `out_rs` is bits [11:8] and `out_rm` is bits [3:0]. The bits [6:5] type code is reported unfolded, `out_shift_amt` is 0 and `out_extra_cycle` is 1.
- R7: For every opcode other than compare and move, slot A is the destination from bits [15:12] and `out_a_written` is 1. Slot B is the source from bits [19:16] and `out_b_valid` is 1. `out_flex_slot` is 3 and `out_set_flags` is bit 20.
- R8: Compare opcodes (bits [24:21] from 8 to 11) put the source from bits [19:16] in slot A with `out_a_written` 0. They give `out_b_valid` 0, `out_b_reg` 0 and `out_flex_slot` 2. `out_set_flags` is 1 whatever bit 20 is.
- R9: Move opcodes (13 and 15) keep the destination in slot A with `out_a_written` 1. They give `out_b_valid` 0, `out_b_reg` 0 and `out_flex_slot` 2, and `out_set_flags` is bit 20.
- R10: `out_branch_ind` is 1 exactly when the opcode writes a result and the destination field is 15, whatever bit 20 is. Compare opcodes never raise it, even when bits [15:12] or [19:16] hold 15.
- R11: `out_opcode` carries bits [24:21]. Bits [31:26] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word present |
| in_word | input | 32 | Instruction word |
| out_valid | output | 1 | Record valid, one cycle after `in_valid` |
| out_opcode | output | 4 | Operation code |
| out_set_flags | output | 1 | Operation writes the flags |
| out_branch_ind | output | 1 | Result goes to the program counter |
| out_a_reg | output | 4 | Register in operand slot A |
| out_a_written | output | 1 | Slot A receives the result |
| out_b_reg | output | 4 | Register in operand slot B |
| out_b_valid | output | 1 | Slot B holds a register source |
| out_flex_slot | output | 2 | Slot of the flexible operand (2 or 3) |
| out_kind | output | 2 | 0 immediate, 1 constant shift, 2 register shift |
| out_shift_type | output | 3 | 0 none, 1 LSL, 2 LSR, 3 ASR, 4 ROR, 5 RRX |
| out_shift_amt | output | 5 | Constant shift amount |
| out_rs | output | 4 | Register holding the shift amount |
| out_rm | output | 4 | Register being shifted |
| out_imm | output | 32 | Expanded immediate |
| out_extra_cycle | output | 1 | Shift by register needs one more cycle |

## Verification
Every record field, and `out_valid`, is due exactly one rising edge after the word is presented. The bench drives on the falling edge and compares on the next falling edge, so exactly one capture edge lies between stimulus and sample. Back-to-back vectors therefore also show that each record replaces the previous one on the following edge.

The hold behaviour is checked in the cycle after `in_valid` drops, with a changed word on the input. Reset clearing is checked while reset is asserted, both before the first vector and in the middle of the run.

// File: rtl/dpd_pkg.sv
package dpd_pkg;

   // Canonical shift codes reported on the record
   typedef enum logic [2:0] {
      SH_NONE = 3'd0,
      SH_LSL  = 3'd1,
      SH_LSR  = 3'd2,
      SH_ASR  = 3'd3,
      SH_ROR  = 3'd4,
      SH_RRX  = 3'd5
   } shift_e;

   // Second-operand classes
   typedef enum logic [1:0] {
      OPK_IMM   = 2'd0,
      OPK_SHIMM = 2'd1,
      OPK_SHREG = 2'd2
   } opkind_e;

   localparam int unsigned SLOT_W = 2;
   localparam logic [SLOT_W-1:0] FLEX_IN_B = 2'd2;
   localparam logic [SLOT_W-1:0] FLEX_IN_C = 2'd3;

   // Opcodes 8..11 only test and set flags
   function automatic logic opc_is_compare(input logic [3:0] opc);
      return opc[3:2] == 2'b10;
   endfunction

   // Opcodes 13 and 15 take no first source
   function automatic logic opc_is_move(input logic [3:0] opc);
      return (opc[3:2] == 2'b11) && opc[0];
   endfunction

   function automatic shift_e raw_to_shift(input logic [1:0] code);
      shift_e s;
      case (code)
         2'b00:   s = SH_LSL;
         2'b01:   s = SH_LSR;
         2'b10:   s = SH_ASR;
         default: s = SH_ROR;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/dpd_imm_expand.sv
module dpd_imm_expand #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IMM8_W = 8,
   parameter int unsigned ROT_W  = 4
) (
   input  logic [IMM8_W-1:0] imm8,
   input  logic [ROT_W-1:0]  rot,
   output logic [DATA_W-1:0] value
);

   // Log-depth rotator: stage k rotates right by 2^(k+1) when rot[k] is set
   logic [ROT_W:0][DATA_W-1:0] stg;

   assign stg[0] = {{(DATA_W-IMM8_W){1'b0}}, imm8};

   for (genvar k = 0; k < ROT_W; k++) begin : g_stage
      localparam int unsigned SH = 2 << k;
      assign stg[k+1] = rot[k] ? {stg[k][SH-1:0], stg[k][DATA_W-1:SH]} : stg[k];
   end

   assign value = stg[ROT_W];

endmodule

// File: rtl/dpd_shift_canon.sv
module dpd_shift_canon
   import dpd_pkg::*;
#(
   parameter int unsigned REG_W     = 4,
   parameter int unsigned SHAMT_W   = 5,
   parameter bit          FOLD_ZERO = 1'b1
) (
   input  logic               imm_form,
   input  logic               reg_amount,
   input  logic [1:0]         type_raw,
   input  logic [SHAMT_W-1:0] amt_raw,
   input  logic [REG_W-1:0]   rs_raw,
   input  logic [REG_W-1:0]   rm_raw,
   output logic [1:0]         kind,
   output logic [2:0]         stype,
   output logic [SHAMT_W-1:0] amt,
   output logic [REG_W-1:0]   rs,
   output logic [REG_W-1:0]   rm,
   output logic               extra
);

   shift_e base_type;
   shift_e const_type;

   assign base_type = raw_to_shift(type_raw);

   // Variant: fold zero-amount constant shifts into canonical codes, or not
   if (FOLD_ZERO) begin : g_fold
      always_comb begin
         const_type = base_type;
         if (amt_raw == '0) begin
            if (base_type == SH_LSL) const_type = SH_NONE;
            else if (base_type == SH_ROR) const_type = SH_RRX;
         end
      end
   end else begin : g_raw
      assign const_type = base_type;
   end

   always_comb begin
      kind  = OPK_IMM;
      stype = SH_NONE;
      amt   = '0;
      rs    = '0;
      rm    = '0;
      extra = 1'b0;
      if (!imm_form) begin
         rm = rm_raw;
         if (reg_amount) begin
            kind  = OPK_SHREG;
            stype = base_type;
            rs    = rs_raw;
            extra = 1'b1;
         end else begin
            kind  = OPK_SHIMM;
            stype = const_type;
            amt   = amt_raw;
         end
      end
   end

endmodule

// File: rtl/dpd_operand_shape.sv
module dpd_operand_shape
   import dpd_pkg::*;
#(
   parameter int unsigned REG_W  = 4,
   parameter int unsigned OPC_W  = 4,
   parameter int unsigned PC_REG = 15
) (
   input  logic [OPC_W-1:0]  opc,
   input  logic              s_bit,
   input  logic [REG_W-1:0]  rd,
   input  logic [REG_W-1:0]  rn,
   output logic [REG_W-1:0]  a_reg,
   output logic              a_written,
   output logic [REG_W-1:0]  b_reg,
   output logic              b_valid,
   output logic [SLOT_W-1:0] flex_slot,
   output logic              set_flags,
   output logic              branch_ind
);

   localparam logic [REG_W-1:0] PC_ID = REG_W'(PC_REG);

   logic is_cmp;
   logic is_mov;

   assign is_cmp = opc_is_compare(opc);
   assign is_mov = opc_is_move(opc);

   always_comb begin
      a_reg     = rd;
      a_written = 1'b1;
      b_reg     = rn;
      b_valid   = 1'b1;
      flex_slot = FLEX_IN_C;
      set_flags = s_bit;
      if (is_cmp) begin
         // no result: everything shifts up one slot
         a_reg     = rn;
         a_written = 1'b0;
         b_reg     = '0;
         b_valid   = 1'b0;
         flex_slot = FLEX_IN_B;
         set_flags = 1'b1;
      end else if (is_mov) begin
         // no first source: flexible operand takes slot B
         b_reg     = '0;
         b_valid   = 1'b0;
         flex_slot = FLEX_IN_B;
      end
   end

   assign branch_ind = a_written && (rd == PC_ID);

endmodule

// File: rtl/dp_operand_decode.sv
module dp_operand_decode
   import dpd_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned REG_W     = 4,
   parameter int unsigned SHAMT_W   = 5,
   parameter int unsigned IMM8_W    = 8,
   parameter int unsigned ROT_W     = 4,
   parameter int unsigned OPC_W     = 4,
   parameter int unsigned PC_REG    = 15,
   parameter bit          FOLD_ZERO = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [DATA_W-1:0]  in_word,
   output logic               out_valid,
   output logic [OPC_W-1:0]   out_opcode,
   output logic               out_set_flags,
   output logic               out_branch_ind,
   output logic [REG_W-1:0]   out_a_reg,
   output logic               out_a_written,
   output logic [REG_W-1:0]   out_b_reg,
   output logic               out_b_valid,
   output logic [1:0]         out_flex_slot,
   output logic [1:0]         out_kind,
   output logic [2:0]         out_shift_type,
   output logic [SHAMT_W-1:0] out_shift_amt,
   output logic [REG_W-1:0]   out_rs,
   output logic [REG_W-1:0]   out_rm,
   output logic [DATA_W-1:0]  out_imm,
   output logic               out_extra_cycle
);

   // Field positions derived from the widths
   localparam int unsigned RM_LSB    = 0;
   localparam int unsigned REGSH_BIT = REG_W;
   localparam int unsigned TYPE_LSB  = REG_W + 1;
   localparam int unsigned AMT_LSB   = TYPE_LSB + 2;
   localparam int unsigned RS_LSB    = IMM8_W;
   localparam int unsigned RD_LSB    = IMM8_W + ROT_W;
   localparam int unsigned RN_LSB    = RD_LSB + REG_W;
   localparam int unsigned S_BIT     = RN_LSB + REG_W;
   localparam int unsigned OPC_LSB   = S_BIT + 1;
   localparam int unsigned IMM_BIT   = OPC_LSB + OPC_W;

   // Elaboration-time consistency checks
   if (AMT_LSB + SHAMT_W != RD_LSB) begin : g_bad_amt
      $error("shift amount field must end below the destination field");
   end
   if (RS_LSB + REG_W != RD_LSB) begin : g_bad_rs
      $error("shift register field must end below the destination field");
   end
   if (IMM_BIT >= DATA_W) begin : g_bad_word
      $error("instruction fields exceed the word width");
   end
   if ((2 << ROT_W) != DATA_W) begin : g_bad_rot
      $error("rotation field must span the whole word in steps of two");
   end
   if ((1 << SHAMT_W) != DATA_W) begin : g_bad_shamt
      $error("shift amount width must address every bit of the word");
   end
   if (PC_REG >= (1 << REG_W)) begin : g_bad_pc
      $error("program counter index does not fit a register number");
   end
   if (OPC_W != 4) begin : g_bad_opc
      $error("opcode classification expects a four-bit opcode");
   end

   // Field extraction
   logic               f_imm_form;
   logic               f_reg_amt;
   logic [1:0]         f_type;
   logic [SHAMT_W-1:0] f_amt;
   logic [REG_W-1:0]   f_rs;
   logic [REG_W-1:0]   f_rm;
   logic [REG_W-1:0]   f_rd;
   logic [REG_W-1:0]   f_rn;
   logic               f_s;
   logic [OPC_W-1:0]   f_opc;
   logic [IMM8_W-1:0]  f_imm8;
   logic [ROT_W-1:0]   f_rot;
   logic               unused_high;

   assign f_imm_form  = in_word[IMM_BIT];
   assign f_reg_amt   = in_word[REGSH_BIT];
   assign f_type      = in_word[TYPE_LSB +: 2];
   assign f_amt       = in_word[AMT_LSB +: SHAMT_W];
   assign f_rs        = in_word[RS_LSB +: REG_W];
   assign f_rm        = in_word[RM_LSB +: REG_W];
   assign f_rd        = in_word[RD_LSB +: REG_W];
   assign f_rn        = in_word[RN_LSB +: REG_W];
   assign f_s         = in_word[S_BIT];
   assign f_opc       = in_word[OPC_LSB +: OPC_W];
   assign f_imm8      = in_word[0 +: IMM8_W];
   assign f_rot       = in_word[IMM8_W +: ROT_W];
   assign unused_high = ^in_word[DATA_W-1:IMM_BIT+1];

   // Second operand
   logic [DATA_W-1:0]  d_imm_full;
   logic [1:0]         d_kind;
   logic [2:0]         d_stype;
   logic [SHAMT_W-1:0] d_amt;
   logic [REG_W-1:0]   d_rs;
   logic [REG_W-1:0]   d_rm;
   logic               d_extra;

   dpd_imm_expand #(
      .DATA_W (DATA_W),
      .IMM8_W (IMM8_W),
      .ROT_W  (ROT_W)
   ) u_imm (
      .imm8  (f_imm8),
      .rot   (f_rot),
      .value (d_imm_full)
   );

   dpd_shift_canon #(
      .REG_W     (REG_W),
      .SHAMT_W   (SHAMT_W),
      .FOLD_ZERO (FOLD_ZERO)
   ) u_shift (
      .imm_form   (f_imm_form),
      .reg_amount (f_reg_amt),
      .type_raw   (f_type),
      .amt_raw    (f_amt),
      .rs_raw     (f_rs),
      .rm_raw     (f_rm),
      .kind       (d_kind),
      .stype      (d_stype),
      .amt        (d_amt),
      .rs         (d_rs),
      .rm         (d_rm),
      .extra      (d_extra)
   );

   // Operand slots and flags
   logic [REG_W-1:0] d_a_reg;
   logic             d_a_wr;
   logic [REG_W-1:0] d_b_reg;
   logic             d_b_valid;
   logic [1:0]       d_flex;
   logic             d_setf;
   logic             d_branch;

   dpd_operand_shape #(
      .REG_W  (REG_W),
      .OPC_W  (OPC_W),
      .PC_REG (PC_REG)
   ) u_shape (
      .opc        (f_opc),
      .s_bit      (f_s),
      .rd         (f_rd),
      .rn         (f_rn),
      .a_reg      (d_a_reg),
      .a_written  (d_a_wr),
      .b_reg      (d_b_reg),
      .b_valid    (d_b_valid),
      .flex_slot  (d_flex),
      .set_flags  (d_setf),
      .branch_ind (d_branch)
   );

   logic [DATA_W-1:0] d_imm;
   assign d_imm = f_imm_form ? d_imm_full : '0;

   // Output record register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid       <= 1'b0;
         out_opcode      <= '0;
         out_set_flags   <= 1'b0;
         out_branch_ind  <= 1'b0;
         out_a_reg       <= '0;
         out_a_written   <= 1'b0;
         out_b_reg       <= '0;
         out_b_valid     <= 1'b0;
         out_flex_slot   <= '0;
         out_kind        <= '0;
         out_shift_type  <= '0;
         out_shift_amt   <= '0;
         out_rs          <= '0;
         out_rm          <= '0;
         out_imm         <= '0;
         out_extra_cycle <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_opcode      <= f_opc;
            out_set_flags   <= d_setf;
            out_branch_ind  <= d_branch;
            out_a_reg       <= d_a_reg;
            out_a_written   <= d_a_wr;
            out_b_reg       <= d_b_reg;
            out_b_valid     <= d_b_valid;
            out_flex_slot   <= d_flex;
            out_kind        <= d_kind;
            out_shift_type  <= d_stype;
            out_shift_amt   <= d_amt;
            out_rs          <= d_rs;
            out_rm          <= d_rm;
            out_imm         <= d_imm;
            out_extra_cycle <= d_extra;
         end
      end
   end

endmodule

// File: rtl/dpd_checker.sv
module dpd_checker #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned REG_W   = 4,
   parameter int unsigned SHAMT_W = 5,
   parameter int unsigned IMM8_W  = 8,
   parameter int unsigned ROT_W   = 4,
   parameter int unsigned OPC_W   = 4,
   parameter int unsigned PC_REG  = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_word,
   input logic              out_valid,
   input logic [OPC_W-1:0]  out_opcode,
   input logic              out_set_flags,
   input logic              out_branch_ind,
   input logic [REG_W-1:0]  out_a_reg,
   input logic              out_a_written,
   input logic [1:0]        out_flex_slot,
   input logic [1:0]        out_kind,
   input logic [2:0]        out_shift_type,
   input logic [DATA_W-1:0] out_imm,
   input logic              out_extra_cycle
);

   localparam int unsigned REGSH_BIT = REG_W;
   localparam int unsigned TYPE_LSB  = REG_W + 1;
   localparam int unsigned AMT_LSB   = TYPE_LSB + 2;
   localparam int unsigned IMM_BIT   = IMM8_W + ROT_W + 2 * REG_W + 1 + OPC_W;

   logic unused_word;
   assign unused_word = ^in_word;

   // R1
   valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R1
   valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R1
   record_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_imm) && $stable(out_a_reg) && $stable(out_kind)
                     && $stable(out_opcode)));

   // R2
   imm_no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_kind == 2'd0) |-> (out_shift_type == 3'd0 && !out_extra_cycle));

   // R5
   rrx_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_word[IMM_BIT] && !in_word[REGSH_BIT]
       && in_word[AMT_LSB +: SHAMT_W] == '0 && in_word[TYPE_LSB +: 2] == 2'b11)
      |=> (out_shift_type == 3'd5));

   // R6
   reg_shift_extra_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_kind == 2'd2) == out_extra_cycle));

   // R8
   compare_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_opcode[3:2] == 2'b10)
      |-> (out_set_flags && !out_a_written && out_flex_slot == 2'd2));

   // R10
   branch_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_branch_ind) |-> (out_a_written && out_a_reg == REG_W'(PC_REG)));

endmodule

bind dp_operand_decode dpd_checker #(
   .DATA_W  (DATA_W),
   .REG_W   (REG_W),
   .SHAMT_W (SHAMT_W),
   .IMM8_W  (IMM8_W),
   .ROT_W   (ROT_W),
   .OPC_W   (OPC_W),
   .PC_REG  (PC_REG)
) u_dpd_chk (.*);

// File: tb/dp_operand_decode_bench.sv
`timescale 1ns/1ps
module dp_operand_decode_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_word = '0;
   logic        out_valid;
   logic [3:0]  out_opcode;
   logic        out_set_flags;
   logic        out_branch_ind;
   logic [3:0]  out_a_reg;
   logic        out_a_written;
   logic [3:0]  out_b_reg;
   logic        out_b_valid;
   logic [1:0]  out_flex_slot;
   logic [1:0]  out_kind;
   logic [2:0]  out_shift_type;
   logic [4:0]  out_shift_amt;
   logic [3:0]  out_rs;
   logic [3:0]  out_rm;
   logic [31:0] out_imm;
   logic        out_extra_cycle;

   always #4 clk = ~clk;

   dp_operand_decode u_dp_operand_decode (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_word (in_word),
      .out_valid (out_valid), .out_opcode (out_opcode),
      .out_set_flags (out_set_flags), .out_branch_ind (out_branch_ind),
      .out_a_reg (out_a_reg), .out_a_written (out_a_written),
      .out_b_reg (out_b_reg), .out_b_valid (out_b_valid),
      .out_flex_slot (out_flex_slot), .out_kind (out_kind),
      .out_shift_type (out_shift_type), .out_shift_amt (out_shift_amt),
      .out_rs (out_rs), .out_rm (out_rm), .out_imm (out_imm),
      .out_extra_cycle (out_extra_cycle)
   );

   typedef struct packed {
      logic [31:0] word;
      logic [1:0]  kind;
      logic [2:0]  stype;
      logic [4:0]  amt;
      logic [3:0]  rm;
      logic [3:0]  rs;
      logic        extra;
      logic [31:0] imm;
      logic [3:0]  a;
      logic        awr;
      logic [3:0]  b;
      logic        bv;
      logic [1:0]  flex;
      logic        setf;
      logic        br;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VECS [NV] = '{
      '{32'hE28214FF, 2'd0, 3'd0, 5'd0,  4'd0,  4'd0, 1'b0, 32'hFF000000, 4'd1,  1'b1, 4'd2, 1'b1, 2'd3, 1'b0, 1'b0},
      '{32'hE3B00101, 2'd0, 3'd0, 5'd0,  4'd0,  4'd0, 1'b0, 32'h40000000, 4'd0,  1'b1, 4'd0, 1'b0, 2'd2, 1'b1, 1'b0},
      '{32'hE20430AB, 2'd0, 3'd0, 5'd0,  4'd0,  4'd0, 1'b0, 32'h000000AB, 4'd3,  1'b1, 4'd4, 1'b1, 2'd3, 1'b0, 1'b0},
      '{32'hE3865FC3, 2'd0, 3'd0, 5'd0,  4'd0,  4'd0, 1'b0, 32'h0000030C, 4'd5,  1'b1, 4'd6, 1'b1, 2'd3, 1'b0, 1'b0},
      '{32'hE0821003, 2'd1, 3'd0, 5'd0,  4'd3,  4'd0, 1'b0, 32'h00000000, 4'd1,  1'b1, 4'd2, 1'b1, 2'd3, 1'b0, 1'b0},
      '{32'hE0487289, 2'd1, 3'd1, 5'd5,  4'd9,  4'd0, 1'b0, 32'h00000000, 4'd7,  1'b1, 4'd8, 1'b1, 2'd3, 1'b0, 1'b0},
      '{32'hE0311062, 2'd1, 3'd5, 5'd0,  4'd2,  4'd0, 1'b0, 32'h00000000, 4'd1,  1'b1, 4'd1, 1'b1, 2'd3, 1'b1, 1'b0},
      '{32'hE0821FE2, 2'd1, 3'd4, 5'd31, 4'd2,  4'd0, 1'b0, 32'h00000000, 4'd1,  1'b1, 4'd2, 1'b1, 2'd3, 1'b0, 1'b0},
      '{32'hE0821024, 2'd1, 3'd2, 5'd0,  4'd4,  4'd0, 1'b0, 32'h00000000, 4'd1,  1'b1, 4'd2, 1'b1, 2'd3, 1'b0, 1'b0},
      '{32'hE08210C5, 2'd1, 3'd3, 5'd1,  4'd5,  4'd0, 1'b0, 32'h00000000, 4'd1,  1'b1, 4'd2, 1'b1, 2'd3, 1'b0, 1'b0},
      '{32'hE0821413, 2'd2, 3'd1, 5'd0,  4'd3,  4'd4, 1'b1, 32'h00000000, 4'd1,  1'b1, 4'd2, 1'b1, 2'd3, 1'b0, 1'b0},
      '{32'hE0821576, 2'd2, 3'd4, 5'd0,  4'd6,  4'd5, 1'b1, 32'h00000000, 4'd1,  1'b1, 4'd2, 1'b1, 2'd3, 1'b0, 1'b0},
      '{32'hE3520005, 2'd0, 3'd0, 5'd0,  4'd0,  4'd0, 1'b0, 32'h00000005, 4'd2,  1'b0, 4'd0, 1'b0, 2'd2, 1'b1, 1'b0},
      '{32'hE103F004, 2'd1, 3'd0, 5'd0,  4'd4,  4'd0, 1'b0, 32'h00000000, 4'd3,  1'b0, 4'd0, 1'b0, 2'd2, 1'b1, 1'b0},
      '{32'hE1A0F00E, 2'd1, 3'd0, 5'd0,  4'd14, 4'd0, 1'b0, 32'h00000000, 4'd15, 1'b1, 4'd0, 1'b0, 2'd2, 1'b0, 1'b1},
      '{32'hE291F000, 2'd0, 3'd0, 5'd0,  4'd0,  4'd0, 1'b0, 32'h00000000, 4'd15, 1'b1, 4'd1, 1'b1, 2'd3, 1'b1, 1'b1},
      '{32'hE1E02153, 2'd2, 3'd3, 5'd0,  4'd3,  4'd1, 1'b1, 32'h00000000, 4'd2,  1'b1, 4'd0, 1'b0, 2'd2, 1'b0, 1'b0},
      '{32'hE17F0000, 2'd1, 3'd0, 5'd0,  4'd0,  4'd0, 1'b0, 32'h00000000, 4'd15, 1'b0, 4'd0, 1'b0, 2'd2, 1'b1, 1'b0},
      '{32'h00487289, 2'd1, 3'd1, 5'd5,  4'd9,  4'd0, 1'b0, 32'h00000000, 4'd7,  1'b1, 4'd8, 1'b1, 2'd3, 1'b0, 1'b0}
   };

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic string form_tag(input logic [31:0] w);
      if (w[25]) return "R2";
      if (w[4]) return "R6";
      if (w[11:7] == 5'd0 && w[6:5] == 2'b00) return "R4";
      if (w[11:7] == 5'd0 && w[6:5] == 2'b11) return "R5";
      return "R3";
   endfunction

   function automatic string shape_tag(input logic [31:0] w);
      if (w[24:23] == 2'b10) return "R8";
      if (w[24:23] == 2'b11 && w[21]) return "R9";
      return "R7";
   endfunction

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", "reset valid", 32'(out_valid), 32'd0);
      chk("R1", "reset imm", out_imm, 32'd0);
      chk("R1", "reset slot A", 32'(out_a_reg), 32'd0);
      chk("R1", "reset kind", 32'(out_kind), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk, back to back
      for (int i = 0; i < NV; i++) begin
         string ft;
         string st;
         in_valid = 1'b1;
         in_word  = VECS[i].word;
         @(negedge clk);
         ft = form_tag(VECS[i].word);
         st = shape_tag(VECS[i].word);
         chk("R1", $sformatf("v%0d valid", i), 32'(out_valid), 32'd1);
         chk(ft, $sformatf("v%0d kind", i), 32'(out_kind), 32'(VECS[i].kind));
         chk(ft, $sformatf("v%0d shift type", i), 32'(out_shift_type), 32'(VECS[i].stype));
         chk(ft, $sformatf("v%0d amount", i), 32'(out_shift_amt), 32'(VECS[i].amt));
         chk(ft, $sformatf("v%0d rm", i), 32'(out_rm), 32'(VECS[i].rm));
         chk(ft, $sformatf("v%0d rs", i), 32'(out_rs), 32'(VECS[i].rs));
         chk(ft, $sformatf("v%0d extra", i), 32'(out_extra_cycle), 32'(VECS[i].extra));
         chk(ft, $sformatf("v%0d imm", i), out_imm, VECS[i].imm);
         chk(st, $sformatf("v%0d slot A", i), 32'(out_a_reg), 32'(VECS[i].a));
         chk(st, $sformatf("v%0d A written", i), 32'(out_a_written), 32'(VECS[i].awr));
         chk(st, $sformatf("v%0d slot B", i), 32'(out_b_reg), 32'(VECS[i].b));
         chk(st, $sformatf("v%0d B valid", i), 32'(out_b_valid), 32'(VECS[i].bv));
         chk(st, $sformatf("v%0d flex slot", i), 32'(out_flex_slot), 32'(VECS[i].flex));
         chk(st, $sformatf("v%0d set flags", i), 32'(out_set_flags), 32'(VECS[i].setf));
         chk("R10", $sformatf("v%0d branch", i), 32'(out_branch_ind), 32'(VECS[i].br));
         chk("R11", $sformatf("v%0d opcode", i), 32'(out_opcode), 32'(VECS[i].word[24:21]));
      end

      // R1: record holds while in_valid is low, even with a new word
      in_valid = 1'b0;
      in_word  = 32'hE3B00101;
      @(negedge clk);
      chk("R1", "hold valid", 32'(out_valid), 32'd0);
      chk("R1", "hold slot A", 32'(out_a_reg), 32'd7);
      chk("R1", "hold kind", 32'(out_kind), 32'd1);
      chk("R1", "hold imm", out_imm, 32'd0);
      chk("R1", "hold opcode", 32'(out_opcode), 32'd2);

      // R1: mid-run reset clears the record
      in_valid = 1'b1;
      @(negedge clk);
      chk("R1", "reload imm", out_imm, 32'h40000000);
      rst_n = 1'b0;
      #1;
      chk("R1", "async reset valid", 32'(out_valid), 32'd0);
      chk("R1", "async reset imm", out_imm, 32'd0);
      chk("R1", "async reset set flags", 32'(out_set_flags), 32'd0);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule